// File: doc/BRIEF.md
# Microoperation Field Decoder with Address Register Transfer

This block sits between a microinstruction register and a small register-transfer datapath. It takes a 9-bit microoperation word and splits it into three independent 3-bit subfields. Each subfield drives its own 3-to-8 decoder, so every subfield selects at most one of its microoperations per cycle.

The decoded outputs of the first subfield drive an address register directly. Two of its codes share one load enable, which is formed by ORing their decoder outputs. The same two outputs steer a two-way source multiplexer. This lets the address register take either the data register value or the program counter value on the next clock edge.

All decoded outputs are also brought out as one-hot strobe vectors, one vector per subfield. The surrounding datapath uses these strobes for the remaining microoperations. A decode-enable input gates every decoder. Code 000 in any subfield is a no-operation and produces no strobe.

Top module: `uop_field_decode`

## Requirements
- R1: The subfields sit at fixed bit positions in `uop_word`: F1 occupies bits 8:6, F2 bits 5:3 and F3 bits 2:0. Each subfield drives only its own strobe vector (`f1_strobe`, `f2_strobe`, `f3_strobe`).
- R2: With `dec_en` high, a subfield holding code k, for k from 1 to 7, raises exactly bit k of its strobe vector, combinationally. No more than one bit of any strobe vector is ever high.
- R3: Code 000 in a subfield leaves its whole strobe vector at zero, and a code 000 in F1 does not load the address register.
- R4: With `dec_en` high and F1 = 101, `ar_q` takes the value of `dr_val` at the next rising clock edge.
- R5: With `dec_en` high and F1 = 110, `ar_q` takes the value of `pc_val` at the next rising clock edge.
- R6: `ar_load` is high exactly when `dec_en` is high and F1 is 101 or 110.
- R7: With any other F1 code, `ar_q` keeps its value across a clock edge, whatever F2, F3, `dr_val` and `pc_val` hold.
- R8: While `dec_en` is low, all three strobe vectors and `ar_load` are zero, and `ar_q` keeps its value even if F1 holds 101 or 110.
- R9: A high `rst` at a rising clock edge clears `ar_q` to zero. Reset is synchronous and active high, and it takes priority over a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Decode enable; low forces every decoder output to zero |
| uop_word | input | 9 | Microoperation word: F1, F2 and F3 subfields |
| dr_val | input | DW (11) | Current data register contents |
| pc_val | input | DW (11) | Current program counter contents |
| ar_q | output | DW (11) | Address register |
| ar_load | output | 1 | Address register load enable (F1 code 5 or 6) |
| f1_strobe | output | 8 | One-hot decode of F1 |
| f2_strobe | output | 8 | One-hot decode of F2 |
| f3_strobe | output | 8 | One-hot decode of F3 |

## Verification
The hardest case to reach is a silent hold. This means proving that the address register does not move when a load looks possible. The stimulus sets F1 to 101 or 110 with `dec_en` low. It also uses the neighbouring F1 codes 100 and 111 with busy F2 and F3 fields. In each case it puts fresh, distinct values on `dr_val` and `pc_val`, so that any wrong load would show up in `ar_q`. Before each hold test, the bench first loads a known value through a legal transfer. A hold therefore cannot hide behind a register that already happens to hold the same value.

// File: rtl/uop_field_decode.sv
module uop_field_decode #(
  parameter int DW   = 11,
  parameter int SUBW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dec_en,
  input  logic [3*SUBW-1:0]    uop_word,
  input  logic [DW-1:0]        dr_val,
  input  logic [DW-1:0]        pc_val,
  output logic [DW-1:0]        ar_q,
  output logic                 ar_load,
  output logic [(1<<SUBW)-1:0] f1_strobe,
  output logic [(1<<SUBW)-1:0] f2_strobe,
  output logic [(1<<SUBW)-1:0] f3_strobe
);
  localparam int NSUB = 3;
  localparam int NOUT = 1 << SUBW;
  localparam int UW   = NSUB * SUBW;
  localparam logic [SUBW-1:0] CODE_DR = SUBW'(5);
  localparam logic [SUBW-1:0] CODE_PC = SUBW'(6);

  logic [NOUT-1:0] dec [NSUB];

  genvar g;
  generate
    for (g = 0; g < NSUB; g++) begin : g_dec
      logic [SUBW-1:0] code;
      assign code   = uop_word[UW-1-g*SUBW -: SUBW];
      assign dec[g] = (dec_en && code != '0) ? (NOUT'(1) << code) : '0;
    end
  endgenerate

  assign f1_strobe = dec[0];
  assign f2_strobe = dec[1];
  assign f3_strobe = dec[2];

  logic [DW-1:0] ar_src;
  assign ar_load = dec[0][CODE_DR] | dec[0][CODE_PC];
  assign ar_src  = dec[0][CODE_PC] ? pc_val : dr_val;

  always_ff @(posedge clk) begin
    if (rst)          ar_q <= '0;
    else if (ar_load) ar_q <= ar_src;
  end

  logic [SUBW-1:0] f1_code;
  assign f1_code = uop_word[UW-1 -: SUBW];

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(f1_strobe) && $onehot0(f2_strobe) && $onehot0(f3_strobe));

  assert_noop_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (uop_word[SUBW-1:0] == '0) |-> (f3_strobe == '0));

  assert_ar_from_dr_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_en && f1_code == CODE_DR) |=> (ar_q == $past(dr_val)));

  assert_ar_from_pc_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_en && f1_code == CODE_PC) |=> (ar_q == $past(pc_val)));

  assert_ar_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (f1_code != CODE_DR && f1_code != CODE_PC) |=> $stable(ar_q));

  assert_disable_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !dec_en |=> $stable(ar_q));

  assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !dec_en |-> (ar_load == 1'b0 && f2_strobe == '0));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (ar_q == '0));
endmodule

// File: tb/uop_field_decode_tb.sv
module uop_field_decode_tb;
  localparam int DW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dec_en = 1'b0;
  logic [8:0]    uop_word = '0;
  logic [DW-1:0] dr_val = '0;
  logic [DW-1:0] pc_val = '0;
  logic [DW-1:0] ar_q;
  logic          ar_load;
  logic [7:0]    f1_strobe, f2_strobe, f3_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uop_field_decode #(.DW(DW), .SUBW(3)) u_dut (
    .clk(clk), .rst(rst), .dec_en(dec_en), .uop_word(uop_word),
    .dr_val(dr_val), .pc_val(pc_val), .ar_q(ar_q), .ar_load(ar_load),
    .f1_strobe(f1_strobe), .f2_strobe(f2_strobe), .f3_strobe(f3_strobe)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [8:0] w,
                       input logic [DW-1:0] d, input logic [DW-1:0] p);
    @(negedge clk);
    dec_en = en; uop_word = w; dr_val = d; pc_val = p;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(1'b1, 9'b101_000_000, 11'h5A5, 11'h0F0);
    @(negedge clk);
    chk(ar_q, 0, "R9 reset beats load");
    rst = 1'b0;
  endtask

  task automatic t_strobes();
    for (int f = 0; f < 3; f++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] e;
        logic [8:0] w;
        w = 9'(c) << (6 - 3*f);
        e = (c == 0) ? 8'h00 : 8'(1 << c);
        drive(1'b1, w, 11'h111, 11'h222);
        chk(f1_strobe, (f == 0) ? e : 8'h00, "R1 R2 R3 f1_strobe");
        chk(f2_strobe, (f == 1) ? e : 8'h00, "R1 R2 R3 f2_strobe");
        chk(f3_strobe, (f == 2) ? e : 8'h00, "R1 R2 R3 f3_strobe");
        chk(ar_load, (f == 0 && (c == 5 || c == 6)), "R6 ar_load");
      end
    end
  endtask

  task automatic t_ar_dr(input logic [DW-1:0] d);
    drive(1'b1, 9'b101_011_110, d, ~d);
    chk(ar_load, 1, "R6 load high for code 5");
    @(negedge clk);
    chk(ar_q, d, "R4 AR takes DR");
  endtask

  task automatic t_ar_pc(input logic [DW-1:0] p);
    drive(1'b1, 9'b110_001_111, ~p, p);
    chk(ar_load, 1, "R6 load high for code 6");
    @(negedge clk);
    chk(ar_q, p, "R5 AR takes PC");
  endtask

  task automatic t_hold();
    for (int c = 0; c < 8; c++) begin
      if (c == 5 || c == 6) continue;
      drive(1'b1, {3'(c), 6'b111_111}, 11'h7FF ^ 11'(c), 11'h155 ^ 11'(c));
      @(negedge clk);
      chk(ar_q, 11'h3C3, (c == 0) ? "R3 noop F1 holds AR" : "R7 AR holds");
    end
  endtask

  task automatic t_disable();
    drive(1'b0, 9'b101_101_101, 11'h001, 11'h002);
    chk(f1_strobe, 0, "R8 f1 quiet");
    chk(f2_strobe, 0, "R8 f2 quiet");
    chk(f3_strobe, 0, "R8 f3 quiet");
    chk(ar_load, 0, "R8 no load");
    @(negedge clk);
    chk(ar_q, 11'h3C3, "R8 AR holds on code 5");
    drive(1'b0, 9'b110_000_000, 11'h004, 11'h008);
    @(negedge clk);
    chk(ar_q, 11'h3C3, "R8 AR holds on code 6");
  endtask

  initial begin
    t_reset();
    t_strobes();
    t_ar_dr(11'h3A5);
    t_ar_pc(11'h4B2);
    t_ar_dr(11'h3C3);
    t_hold();
    t_disable();
    t_ar_pc(11'h7FF);
    rst = 1'b1;
    drive(1'b0, 9'h000, '0, '0);
    @(negedge clk);
    chk(ar_q, 0, "R9 reset clears AR");
    rst = 1'b0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule